// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block keeps the fetch address of an 11-bit, 2048-word instruction space. It also holds a two-slot hardware return stack. Each clock the surrounding sequencer gives one operation code. The operation is one of: step to the next word, step over one word, jump, call a subroutine, return, or write the counter from the ALU result.

The instruction space is split into four pages of 512 words. Jumps, calls and ALU writes take the page number from two bits of the status register. Only a narrow immediate or data field fills the offset inside the page. A call can reach only the lower half of a page. A return restores the full 11-bit address from the stack. When the stack is full, a further call overwrites the oldest slot. Extra returns keep rotating through the two slots.

The fetch address drives program memory directly. Both stack slots are visible at the ports.

Top module: `paged_pc`

## Requirements
- R1: While `rst_n` is low on a clock edge, the fetch address and both stack slots become 11'h7FF.
- R2: Operation code 0 (step), and the unused codes 6 and 7, set the fetch address to the previous value plus 1, modulo 2048, so 7FF is followed by 000.
- R3: Operation code 1 (skip) adds 2 modulo 2048, so 7FE goes to 000 and 7FF goes to 001.
- R4: Operation code 2 (jump) loads `{page, imm[8:0]}`, with `page` in bits 10:9.
- R5: Operation code 3 (call) loads `{page, 1'b0, imm[7:0]}`, and `imm[8]` has no effect. It pushes the old fetch address plus 1, modulo 2048, so after the call `ret_addr` shows that value.
- R6: Operation code 5 (PC write) loads `{page, 1'b0, alu[7:0]}`. The stack is unchanged.
- R7: Operation code 4 (return) loads the value that `ret_addr` showed before the edge. The page bits are ignored.
- R8: The stack holds two entries. After two calls, `ret_addr` shows the newer return address and `alt_addr` shows the older one. A third call overwrites the oldest entry.
- R9: After two returns have removed both pushed entries, a third return yields the most recently pushed address again. The stack slots only rotate and never change their contents on a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op | input | 3 | Operation code for this cycle |
| imm | input | 9 | Target offset field for jump and call |
| alu | input | 8 | ALU result used by a PC write |
| page | input | 2 | Page bits taken from the status register |
| fetch_addr | output | 11 | Current program counter |
| ret_addr | output | 11 | Address the next return would load |
| alt_addr | output | 11 | The other stack slot |

## Verification
A corrupted counter shows on `fetch_addr` on the clock after the faulty operation, because every operation writes the counter. A stack pointer that flips at the wrong time swaps `ret_addr` and `alt_addr` at once. A wrong slot write changes one of them on the edge of the call. The bench compares all three outputs every cycle against its own model. A stack fault is therefore seen one cycle after it happens, not only at the later return that would use the wrong value.

// File: rtl/paged_pc.sv
module paged_pc #(
  parameter int AW = 11,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op,
  input  logic [AW-PW-1:0] imm,
  input  logic [AW-PW-2:0] alu,
  input  logic [PW-1:0] page,
  output logic [AW-1:0] fetch_addr,
  output logic [AW-1:0] ret_addr,
  output logic [AW-1:0] alt_addr
);
  localparam int OFFW = AW - PW;
  localparam int HALFW = OFFW - 1;
  localparam logic [2:0] OP_STEP = 3'd0, OP_SKIP = 3'd1, OP_JUMP = 3'd2,
                         OP_CALL = 3'd3, OP_RET = 3'd4, OP_PCWR = 3'd5;

  logic [AW-1:0] pc, slot0, slot1;
  logic          wsel;

  wire [AW-1:0] pc_next1 = pc + AW'(1);
  wire [AW-1:0] pc_next2 = pc + AW'(2);

  assign fetch_addr = pc;
  assign ret_addr   = wsel ? slot0 : slot1;
  assign alt_addr   = wsel ? slot1 : slot0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc    <= '1;
      slot0 <= '1;
      slot1 <= '1;
      wsel  <= 1'b0;
    end else begin
      case (op)
        OP_SKIP: pc <= pc_next2;
        OP_JUMP: pc <= {page, imm};
        OP_CALL: begin
          pc <= {page, 1'b0, imm[HALFW-1:0]};
          if (wsel) slot1 <= pc_next1;
          else      slot0 <= pc_next1;
          wsel <= ~wsel;
        end
        OP_RET: begin
          pc   <= ret_addr;
          wsel <= ~wsel;
        end
        OP_PCWR: pc <= {page, 1'b0, alu};
        default: pc <= pc_next1;
      endcase
    end
  end

  a_r1_reset_value: assert property (@(posedge clk) $rose(rst_n) |-> fetch_addr == '1);
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_STEP |=> fetch_addr == $past(fetch_addr) + AW'(1));
  a_r3_skip: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_SKIP |=> fetch_addr == $past(fetch_addr) + AW'(2));
  a_r4_jump: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_JUMP |=> fetch_addr == {$past(page), $past(imm)});
  a_r5_call_push: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_CALL |=> !fetch_addr[HALFW] && ret_addr == $past(fetch_addr) + AW'(1)
                      && alt_addr == $past(ret_addr));
  a_r6_pcwr_keeps_stack: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_PCWR |=> $stable(ret_addr) && $stable(alt_addr) && !fetch_addr[HALFW]);
  a_r7_return: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_RET |=> fetch_addr == $past(ret_addr));
  a_r9_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_RET |=> ret_addr == $past(alt_addr) && alt_addr == $past(ret_addr));
endmodule

// File: tb/paged_pc_test.sv
`timescale 1ns/1ps
module paged_pc_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] op = '0;
  logic [8:0] imm = '0;
  logic [7:0] alu = '0;
  logic [1:0] page = '0;
  logic [10:0] fetch_addr, ret_addr, alt_addr;

  int checks = 0, fails = 0;
  bit done = 0;

  int m_pc;
  int m_ring[2];
  int m_lvl;

  always #2.5 clk = ~clk;

  paged_pc uut (.clk(clk), .rst_n(rst_n), .op(op), .imm(imm), .alu(alu),
                .page(page), .fetch_addr(fetch_addr), .ret_addr(ret_addr),
                .alt_addr(alt_addr));

  function automatic int idx(int v);
    return ((v % 2) + 2) % 2;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%03h expected=%03h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check(tag, "fetch_addr", fetch_addr, m_pc);
    check(tag, "ret_addr", ret_addr, m_ring[idx(m_lvl - 1)]);
    check(tag, "alt_addr", alt_addr, m_ring[idx(m_lvl)]);
  endtask

  task automatic step(string tag, int o, int i, int a, int p);
    op = 3'(o); imm = 9'(i); alu = 8'(a); page = 2'(p);
    case (o)
      1: m_pc = (m_pc + 2) % 2048;
      2: m_pc = p * 512 + i;
      3: begin
        m_ring[idx(m_lvl)] = (m_pc + 1) % 2048;
        m_lvl++;
        m_pc = p * 512 + (i % 256);
      end
      4: begin
        m_pc = m_ring[idx(m_lvl - 1)];
        m_lvl--;
      end
      5: m_pc = p * 512 + a;
      default: m_pc = (m_pc + 1) % 2048;
    endcase
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    m_pc = 2047; m_ring[0] = 2047; m_ring[1] = 2047; m_lvl = 0;
    compare("R1");
    rst_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    step("R2", 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0);
    step("R4", 2, 9'h1FE, 0, 3);
    step("R2", 6, 0, 0, 0);
    step("R2", 7, 0, 0, 0);
    step("R3", 2, 9'h1FE, 0, 3);
    step("R3", 1, 0, 0, 0);
    step("R4", 2, 9'h1FF, 0, 3);
    step("R3", 1, 0, 0, 0);
    step("R4", 2, 9'h0A5, 0, 2);
    step("R5", 3, 9'h1C3, 0, 1);
    step("R8", 3, 9'h111, 0, 2);
    step("R8", 3, 9'h022, 0, 0);
    step("R7", 4, 0, 0, 3);
    step("R7", 4, 0, 0, 1);
    step("R9", 4, 0, 0, 0);
    step("R6", 5, 0, 8'hC4, 2);
    step("R6", 5, 0, 8'h00, 1);
    step("R4", 2, 9'h1FF, 0, 3);
    step("R5", 3, 9'h1FF, 0, 0);
    step("R7", 4, 0, 0, 2);
    do_reset();
    step("R7", 4, 0, 0, 1);
    for (int n = 0; n < 400; n++)
      step("R9", $urandom_range(0, 7), $urandom_range(0, 511),
           $urandom_range(0, 255), $urandom_range(0, 3));
    do_reset();
    step("R2", 0, 0, 0, 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule